// File: doc/BRIEF.md
# UART Baud Clock Generator

This block produces the oversampling clock enables for two UARTs. Each UART has a transmit direction and a receive direction, and each of the four directions gets its own clock. For every direction the block drives two single-cycle enables. One marks each 16x sample point. The other marks each bit period, which is one in every sixteen sample points.

The system clock first goes through a shared prescaler that divides by 4, 16 or 64. The prescaled tick steps two auto-reload timers: a short 8-bit timer and a long 16-bit timer. Each timer counts up and, when it passes its all-ones value, reloads from its reload register. Each overflow is one 16x sample tick. A direction whose UART runs in a timer mode takes its ticks from one of the two timers, chosen by that direction's own select bit. A UART in a fixed mode ignores both timers. Its directions tick on every system clock (mode 0, baud = clock/16) or on every second clock (mode 2, baud = clock/32).

Configuration arrives through a write-only port of address, data and enable. The register map is:

| Address | Contents |
|---------|----------|
| 0 | prescaler code in bits 1:0 |
| 1 | short reload value in bits 7:0 |
| 2 | long reload value in bits 15:0 |
| 3 | long-timer select, bit d for direction d |
| 4 | UART0 mode in bits 1:0, UART1 mode in bits 3:2 |

Directions are numbered 0 = UART0 transmit, 1 = UART0 receive, 2 = UART1 transmit and 3 = UART1 receive.

Top module: `baud_clkgen`

## Requirements
- R1: Prescaler code 00, 01 and 10 step the timers once every 4, 16 and 64 clocks. With short reload 255 and a UART in mode 1, the directions of that UART therefore tick every 4, 16 or 64 clocks.
- R2: For a direction in mode 1 or 3 with its select bit clear, the 16x tick comes once every N*(256-reload) clocks, where N is the prescaler divisor and reload is the short reload value.
- R3: For a direction in mode 1 or 3 with its select bit set, the 16x tick comes once every N*(65536-reload) clocks, where reload is the long reload value.
- R4: Select bit d (address 3) affects only direction d. Directions of the same UART can run at different rates at the same time.
- R5: Mode 0 gives a 16x tick on every clock and mode 2 on every second clock, whatever the select bits and timers hold.
- R6: A bit tick is issued on every sixteenth 16x tick of the same direction, in the same cycle as that 16x tick.
- R7: While the prescaler code is 11, the timers stand still. Directions fed by a timer then issue no ticks.
- R8: A timer reloads in the same prescaled step in which it overflows, so no step is lost. Short reload 255 with divisor 4 gives a tick every 4 clocks, which is the fastest timer rate.
- R9: Short reload 0 with divisor 4 gives the slowest short-timer rate, one tick every 1024 clocks.
- R10: When a direction's clock source changes, its bit counter restarts. The first bit tick after the change falls on the sixteenth 16x tick from the new source.
- R11: During reset both outputs are low. After reset all UARTs are in mode 0, so every direction issues a 16x tick on every clock.
- R12: Writes to addresses 5 to 7 change no setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| os_tick | output | 4 | 16x sample enable, one bit per direction |
| bit_tick | output | 4 | Bit-period enable, one bit per direction |

## Verification
A write lands on clock edge E, and its latency depends on the path. For a fixed-mode direction, the new rate shows on os_tick from edge E+1. For a timer-fed direction, the path has three registers: the prescaler restarts at E, its first step is registered N clocks later, the timer overflow registers one clock after that step, and os_tick registers one clock after the overflow. The bench therefore does not time the first interval after a change. It samples at the falling edge, discards two tick intervals and measures the third. For the bit-counter restart, it counts 16x ticks starting with the sample taken after edge E+1, which is the first cycle on which the new source can appear.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_PRESC = 3'd0;
    localparam logic [ADDR_W-1:0] A_RLD_S = 3'd1;
    localparam logic [ADDR_W-1:0] A_RLD_L = 3'd2;
    localparam logic [ADDR_W-1:0] A_SEL   = 3'd3;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd4;

    localparam logic [1:0] PRESC_OFF     = 2'b11;
    localparam logic [1:0] MODE_FIX_FAST = 2'd0;
    localparam logic [1:0] MODE_FIX_HALF = 2'd2;

    typedef enum logic [1:0] {
        SRC_FAST  = 2'd0,
        SRC_HALF  = 2'd1,
        SRC_SHORT = 2'd2,
        SRC_LONG  = 2'd3
    } src_e;

endpackage

// File: rtl/bclk_prescaler.sv
module bclk_prescaler
    import baud_pkg::*;
#(
    parameter int STEP_LOG = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       restart,
    output logic       tick
);
    localparam int CNT_W = 3 * STEP_LOG;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } pre_t;

    pre_t pre_d, pre_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        unique case (sel)
            2'd0:    last = CNT_W'((1 << STEP_LOG) - 1);
            2'd1:    last = CNT_W'((1 << (2 * STEP_LOG)) - 1);
            default: last = '1;
        endcase

        pre_d      = pre_q;
        pre_d.tick = 1'b0;
        if (restart || sel == PRESC_OFF) begin
            pre_d.cnt = '0;
        end else if (pre_q.cnt == last) begin
            pre_d.cnt  = '0;
            pre_d.tick = 1'b1;
        end else begin
            pre_d.cnt = pre_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick = pre_q.tick;

endmodule

// File: rtl/bclk_reload_timer.sv
module bclk_reload_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload,
    output logic         ovf
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         ovf;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d     = tmr_q;
        tmr_d.ovf = 1'b0;
        if (load) begin
            tmr_d.cnt = load_val;
        end else if (step) begin
            if (&tmr_q.cnt) begin
                tmr_d.cnt = reload;
                tmr_d.ovf = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign ovf = tmr_q.ovf;

endmodule

// File: rtl/bclk_lane.sv
module bclk_lane
    import baud_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  src_e src,
    input  logic tick_half,
    input  logic tick_short,
    input  logic tick_long,
    output logic os_tick,
    output logic bit_tick
);
    localparam int PH_W = $clog2(OVS);

    typedef struct packed {
        src_e            src;
        logic [PH_W-1:0] ph;
        logic            os;
        logic            bt;
    } lane_t;

    lane_t lane_d, lane_q;
    logic  sel_tick;

    always_comb begin
        unique case (src)
            SRC_FAST:  sel_tick = 1'b1;
            SRC_HALF:  sel_tick = tick_half;
            SRC_SHORT: sel_tick = tick_short;
            default:   sel_tick = tick_long;
        endcase

        lane_d     = lane_q;
        lane_d.src = src;
        lane_d.os  = sel_tick;
        lane_d.bt  = 1'b0;
        if (src != lane_q.src) begin
            lane_d.ph = sel_tick ? PH_W'(1) : '0;
        end else if (sel_tick) begin
            if (lane_q.ph == PH_W'(OVS - 1)) begin
                lane_d.ph = '0;
                lane_d.bt = 1'b1;
            end else begin
                lane_d.ph = lane_q.ph + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q     <= '0;
            lane_q.src <= SRC_FAST;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign os_tick  = lane_q.os;
    assign bit_tick = lane_q.bt;

endmodule

// File: rtl/baud_clkgen.sv
module baud_clkgen
    import baud_pkg::*;
#(
    parameter int NUM_UART = 2,
    parameter int SHORT_W  = 8,
    parameter int LONG_W   = 16,
    parameter int OVS      = 16,
    parameter int STEP_LOG = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [LONG_W-1:0]     wr_data,
    output logic [2*NUM_UART-1:0] os_tick,
    output logic [2*NUM_UART-1:0] bit_tick
);
    localparam int DIRS   = 2 * NUM_UART;
    localparam int MODE_W = 2 * NUM_UART;

    typedef struct packed {
        logic [1:0]         presc;
        logic [SHORT_W-1:0] rld_s;
        logic [LONG_W-1:0]  rld_l;
        logic [DIRS-1:0]    use_long;
        logic [MODE_W-1:0]  mode;
        logic               half;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic presc_wr, load_s, load_l;
    logic ptick, ovf_s, ovf_l;
    logic [1:0] presc_sel;

    assign presc_wr  = wr_en && (wr_addr == A_PRESC);
    assign load_s    = wr_en && (wr_addr == A_RLD_S);
    assign load_l    = wr_en && (wr_addr == A_RLD_L);
    assign presc_sel = cfg_q.presc;

    always_comb begin
        cfg_d      = cfg_q;
        cfg_d.half = ~cfg_q.half;
        if (wr_en) begin
            unique case (wr_addr)
                A_PRESC: cfg_d.presc    = wr_data[1:0];
                A_RLD_S: cfg_d.rld_s    = wr_data[SHORT_W-1:0];
                A_RLD_L: cfg_d.rld_l    = wr_data[LONG_W-1:0];
                A_SEL:   cfg_d.use_long = wr_data[DIRS-1:0];
                A_MODE:  cfg_d.mode     = wr_data[MODE_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    bclk_prescaler #(.STEP_LOG(STEP_LOG)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (cfg_q.presc),
        .restart (presc_wr),
        .tick    (ptick)
    );

    bclk_reload_timer #(.W(SHORT_W)) u_tmr_s (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (ptick),
        .load     (load_s),
        .load_val (wr_data[SHORT_W-1:0]),
        .reload   (cfg_q.rld_s),
        .ovf      (ovf_s)
    );

    bclk_reload_timer #(.W(LONG_W)) u_tmr_l (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (ptick),
        .load     (load_l),
        .load_val (wr_data[LONG_W-1:0]),
        .reload   (cfg_q.rld_l),
        .ovf      (ovf_l)
    );

    for (genvar d = 0; d < DIRS; d++) begin : g_lane
        logic [1:0] mode;
        src_e       src;

        assign mode = cfg_q.mode[2*(d/2) +: 2];

        always_comb begin
            if (mode == MODE_FIX_FAST)      src = SRC_FAST;
            else if (mode == MODE_FIX_HALF) src = SRC_HALF;
            else if (cfg_q.use_long[d])     src = SRC_LONG;
            else                            src = SRC_SHORT;
        end

        bclk_lane #(.OVS(OVS)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .src        (src),
            .tick_half  (cfg_q.half),
            .tick_short (ovf_s),
            .tick_long  (ovf_l),
            .os_tick    (os_tick[d]),
            .bit_tick   (bit_tick[d])
        );
    end

endmodule

// File: rtl/baud_clkgen_chk.sv
module baud_clkgen_chk #(
    parameter int DIRS = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [DIRS-1:0] os_tick,
    input logic [DIRS-1:0] bit_tick,
    input logic [1:0]      presc,
    input logic            ptick,
    input logic            ovf_s,
    input logic            ovf_l
);

    // R6
    bit_with_os_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bit_tick & ~os_tick) == '0));

    // R1
    ptick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptick |=> !ptick);

    // R7
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (presc == 2'b11 && $past(presc) == 2'b11) |=> !(ovf_s || ovf_l));

    // R2
    short_ovf_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_s |-> $past(ptick));

    // R3
    long_ovf_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_l |-> $past(ptick));

endmodule

bind baud_clkgen baud_clkgen_chk #(.DIRS(2*NUM_UART)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .os_tick  (os_tick),
    .bit_tick (bit_tick),
    .presc    (presc_sel),
    .ptick    (ptick),
    .ovf_s    (ovf_s),
    .ovf_l    (ovf_l)
);

// File: tb/baud_clkgen_tb.sv
module baud_clkgen_tb_top;

    localparam int CLK_P = 10;
    localparam int LIMIT = 4000;
    localparam int WD    = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  os_tick, bit_tick;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    baud_clkgen dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .os_tick  (os_tick),
        .bit_tick (bit_tick)
    );

    initial forever #(CLK_P/2) clk = ~clk;

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=%0d expected<%0d cycles", WD, WD);
            report();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_tick(input int d, input bit on_bit, output int cyc);
        bit hit;
        cyc = 0;
        hit = 1'b0;
        while (!hit && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
            hit = on_bit ? bit_tick[d] : os_tick[d];
        end
    endtask

    task automatic get_period(input int d, input bit on_bit, output int p);
        int c;
        wait_tick(d, on_bit, c);
        wait_tick(d, on_bit, c);
        wait_tick(d, on_bit, p);
    endtask

    task automatic t_reset();
        int p;
        repeat (3) @(negedge clk);
        check(os_tick == 4'h0 && bit_tick == 4'h0, "R11 outputs low in reset",
              int'({os_tick, bit_tick}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(os_tick == 4'hF, "R11 mode 0 after reset", int'(os_tick), 15);
        get_period(3, 1'b0, p);
        check(p == 1, "R5 mode 0 every clock", p, 1);
    endtask

    task automatic t_prescale();
        int p;
        wr(3'd4, 16'h0005);
        wr(3'd3, 16'h0000);
        wr(3'd1, 16'd255);
        wr(3'd0, 16'd0);
        get_period(0, 1'b0, p);
        check(p == 4, "R8 reload 255 divisor 4", p, 4);
        wr(3'd0, 16'd1);
        get_period(1, 1'b0, p);
        check(p == 16, "R1 code 01", p, 16);
        wr(3'd0, 16'd2);
        get_period(0, 1'b0, p);
        check(p == 64, "R1 code 10", p, 64);
    endtask

    task automatic t_reload8();
        int p;
        wr(3'd0, 16'd0);
        wr(3'd1, 16'd253);
        get_period(0, 1'b0, p);
        check(p == 12, "R2 short reload 253", p, 12);
        get_period(0, 1'b1, p);
        check(p == 192, "R6 bit tick every 16", p, 192);
        wr(3'd1, 16'd0);
        get_period(1, 1'b0, p);
        check(p == 1024, "R9 short reload 0", p, 1024);
    endtask

    task automatic t_long();
        int p;
        wr(3'd1, 16'd253);
        wr(3'd2, 16'd65531);
        wr(3'd4, 16'h0009);
        wr(3'd3, 16'h000E);
        get_period(1, 1'b0, p);
        check(p == 20, "R3 long reload 65531", p, 20);
        get_period(0, 1'b0, p);
        check(p == 12, "R4 direction 0 keeps short timer", p, 12);
        get_period(2, 1'b0, p);
        check(p == 2, "R5 mode 2 ignores select", p, 2);
        get_period(3, 1'b0, p);
        check(p == 2, "R5 mode 2 receive", p, 2);
    endtask

    task automatic t_reserved();
        int cnt;
        int p;
        wr(3'd0, 16'd3);
        repeat (5) @(negedge clk);
        cnt = 0;
        repeat (200) begin
            @(negedge clk);
            cnt += int'(os_tick[0]) + int'(os_tick[1]);
        end
        check(cnt == 0, "R7 reserved code stops timers", cnt, 0);
        get_period(2, 1'b0, p);
        check(p == 2, "R7 fixed mode unaffected", p, 2);
        wr(3'd0, 16'd0);
        get_period(0, 1'b0, p);
        check(p == 12, "R1 restart after reserved", p, 12);
    endtask

    task automatic t_ignore();
        int p;
        wr(3'd5, 16'h0000);
        wr(3'd6, 16'hFFFF);
        wr(3'd7, 16'h0000);
        get_period(0, 1'b0, p);
        check(p == 12, "R12 unused addresses ignored", p, 12);
        get_period(1, 1'b0, p);
        check(p == 20, "R12 long path unchanged", p, 20);
    endtask

    task automatic t_restart();
        int c;
        int n;
        bit hit;
        wr(3'd4, 16'h0005);
        wr(3'd3, 16'h0000);
        wr(3'd1, 16'd255);
        wr(3'd2, 16'd65535);
        wr(3'd0, 16'd0);
        wait_tick(0, 1'b1, c);
        repeat (7) wait_tick(0, 1'b0, c);
        wr(3'd3, 16'h0001);
        n = 0;
        hit = 1'b0;
        c = 0;
        while (!hit && c < LIMIT) begin
            @(negedge clk);
            c++;
            if (os_tick[0]) n++;
            hit = bit_tick[0];
        end
        check(n == 16, "R10 bit counter restarts on source change", n, 16);
    endtask

    initial begin
        t_reset();
        t_prescale();
        t_reload8();
        t_long();
        t_reserved();
        t_ignore();
        t_restart();
        done = 1'b1;
        report();
        $finish;
    end

endmodule